// File: doc/BRIEF.md
# Masked Data Watchpoint Unit

This block watches the data-memory access stream of a core for addresses that software has marked as interesting. It holds a small set of watchpoints. Each one has an address register and a control register. The control register selects whether the watchpoint fires on reads, on writes, or on both. It also holds a mask field that widens the watched address into an aligned, power-of-two sized region.

On every access the block compares the address and the direction with each armed watchpoint. It raises a combinational hit in the same cycle the access is presented, so the pipeline can stop the access before it takes effect. When more than one watchpoint matches, the lowest-numbered one is reported. A mask field with a hole in it is not rejected. It is cut back to its leading run of ones, so the region size is always a power of two.

Top module: `wp_unit`

## Requirements
- R1: After reset every watchpoint is disarmed, so no access hits until software programs one.
- R2: A watchpoint fires on an access with `acc_store` set only if its store-enable bit is set. The store-enable bit is control bit MASK_W+1, which is bit 7 by default.
- R3: A watchpoint fires on an access with `acc_load` set only if its load-enable bit is set. The load-enable bit is control bit MASK_W, which is bit 6 by default.
- R4: Control bits [MASK_W-1:0] form the mask field. Field bit i governs address bit i, and every address bit above the field always takes part in the compare. An access matches when (acc_addr AND mask) equals (watch address AND mask). The watched region spans (NOT mask)+1 bytes.
- R5: A mask field that is not contiguous is cut back when it is written. Only the ones above its highest zero bit are kept, and every lower bit becomes zero. For example, field 6'b101111 acts as 6'b100000.
- R6: A watchpoint whose two enable bits are both clear never fires.
- R7: When several watchpoints match the same access, `bp_idx` reports the lowest-numbered one.
- R8: A register write takes effect for accesses from the next cycle on. An access presented in the same cycle as the write is judged against the old contents.
- R9: `bp_hit` is combinational in the cycle the access is presented, and it is low whenever `acc_valid` is low.
- R10: `bp_idx` is zero whenever `bp_hit` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_ctrl | input | 1 | 1 = write the control register, 0 = write the address register |
| wr_idx | input | IDX_W | Watchpoint selected for the write |
| wr_data | input | ADDR_W | Write data |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | ADDR_W | Access address |
| acc_load | input | 1 | The access reads memory |
| acc_store | input | 1 | The access writes memory |
| bp_hit | output | 1 | An armed watchpoint matches the access |
| bp_idx | output | IDX_W | Lowest-numbered matching watchpoint |

## Verification
`bp_hit` and `bp_idx` are due in the same cycle as the access. The bench therefore drives each access just after a falling edge and samples both outputs one nanosecond later, well before the next rising edge. A register write counts from the rising edge that ends its cycle. The bench model applies the write only after that edge, so an access presented in the same cycle as a write is checked against the old configuration. The next access is checked against the new one.

// File: rtl/wp_pkg.sv
package wp_pkg;

    typedef enum logic {
        WP_SEL_ADDR = 1'b0,
        WP_SEL_CTRL = 1'b1
    } wp_sel_e;

    typedef struct packed {
        logic ld;
        logic st;
    } wp_dir_t;

endpackage

// File: rtl/wp_mask_norm.sv
module wp_mask_norm #(
    parameter int MASK_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MASK_W-1:0] field_raw,
    output logic [MASK_W-1:0] field_norm
);

    always_comb begin
        logic keep;
        keep = 1'b1;
        for (int i = MASK_W - 1; i >= 0; i--) begin
            keep          = keep & field_raw[i];
            field_norm[i] = keep;
        end
    end

    logic [MASK_W-1:0] inv_norm;
    assign inv_norm = ~field_norm;

    // R5: the result is a run of leading ones
    a_r5_norm_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        ((inv_norm & (inv_norm + 1'b1)) == '0));

    // R5: truncation only clears bits, it never sets one
    a_r5_norm_subset: assert property (@(posedge clk) disable iff (!rst_n)
        ((field_norm & ~field_raw) == '0));

endmodule

// File: rtl/wp_match.sv
module wp_match #(
    parameter int ADDR_W = 32,
    parameter int MASK_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] wp_addr,
    input  logic [MASK_W-1:0] wp_mask,
    input  wp_pkg::wp_dir_t   wp_en,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  wp_pkg::wp_dir_t   acc_dir,
    output logic              match
);

    localparam int HI_W = ADDR_W - MASK_W;

    logic [ADDR_W-1:0] full_mask;
    logic              addr_eq;
    logic              dir_ok;

    assign full_mask = {{HI_W{1'b1}}, wp_mask};
    assign addr_eq   = ((acc_addr & full_mask) == (wp_addr & full_mask));
    assign dir_ok    = (acc_dir.ld & wp_en.ld) | (acc_dir.st & wp_en.st);
    assign match     = acc_valid & dir_ok & addr_eq;

    // R6: a watchpoint with both enables clear stays silent
    a_r6_disarmed_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (!wp_en.ld && !wp_en.st) |-> !match);

endmodule

// File: rtl/wp_prio.sv
module wp_prio #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

    assign any = |req;

    // R7: the reported index is itself a request
    a_r7_idx_requested: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> req[idx]);

    // R7: no lower-numbered request was passed over
    a_r7_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> ((req & ~({N{1'b1}} << idx)) == '0));

endmodule

// File: rtl/wp_unit.sv
module wp_unit #(
    parameter int NUM_BP = 4,
    parameter int ADDR_W = 32,
    parameter int MASK_W = 6,
    localparam int IDX_W = (NUM_BP > 1) ? $clog2(NUM_BP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_ctrl,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_load,
    input  logic              acc_store,
    output logic              bp_hit,
    output logic [IDX_W-1:0]  bp_idx
);

    localparam int LD_BIT = MASK_W;
    localparam int ST_BIT = MASK_W + 1;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [MASK_W-1:0] mask;
        wp_pkg::wp_dir_t   en;
    } wp_entry_t;

    wp_entry_t [NUM_BP-1:0] bp_d, bp_q;
    logic [MASK_W-1:0]      norm_mask;
    logic [NUM_BP-1:0]      match_vec;
    wp_pkg::wp_dir_t        acc_dir;
    wp_pkg::wp_sel_e        sel;

    assign acc_dir.ld = acc_load;
    assign acc_dir.st = acc_store;
    assign sel        = wp_pkg::wp_sel_e'(wr_ctrl);

    wp_mask_norm #(.MASK_W(MASK_W)) i_norm (
        .clk        (clk),
        .rst_n      (rst_n),
        .field_raw  (wr_data[MASK_W-1:0]),
        .field_norm (norm_mask)
    );

    always_comb begin
        bp_d = bp_q;
        if (wr_en && (int'(wr_idx) < NUM_BP)) begin
            if (sel == wp_pkg::WP_SEL_CTRL) begin
                bp_d[wr_idx].mask   = norm_mask;
                bp_d[wr_idx].en.ld  = wr_data[LD_BIT];
                bp_d[wr_idx].en.st  = wr_data[ST_BIT];
            end else begin
                bp_d[wr_idx].addr   = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bp_q <= '0;
        end else begin
            bp_q <= bp_d;
        end
    end

    for (genvar g = 0; g < NUM_BP; g++) begin : g_cmp
        wp_match #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) i_match (
            .clk       (clk),
            .rst_n     (rst_n),
            .wp_addr   (bp_q[g].addr),
            .wp_mask   (bp_q[g].mask),
            .wp_en     (bp_q[g].en),
            .acc_valid (acc_valid),
            .acc_addr  (acc_addr),
            .acc_dir   (acc_dir),
            .match     (match_vec[g])
        );
    end

    wp_prio #(.N(NUM_BP), .IDX_W(IDX_W)) i_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (match_vec),
        .any   (bp_hit),
        .idx   (bp_idx)
    );

    // R8: stored configuration only changes after a write
    a_r8_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bp_q));

    // R9: no access, no hit
    a_r9_idle_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> !bp_hit);

    // R10: index parks at zero without a hit
    a_r10_idx_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bp_hit |-> (bp_idx == '0));

endmodule

// File: tb/test_wp_unit.sv
module test_wp_unit;

    localparam int NUM_BP = 4;
    localparam int ADDR_W = 32;
    localparam int MASK_W = 6;
    localparam int IDX_W  = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              wr_ctrl = 1'b0;
    logic [IDX_W-1:0]  wr_idx = '0;
    logic [ADDR_W-1:0] wr_data = '0;
    logic              acc_valid = 1'b0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic              acc_load = 1'b0;
    logic              acc_store = 1'b0;
    logic              bp_hit;
    logic [IDX_W-1:0]  bp_idx;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [ADDR_W-1:0] m_addr [NUM_BP];
    logic [MASK_W-1:0] m_mask [NUM_BP];
    logic              m_ld   [NUM_BP];
    logic              m_st   [NUM_BP];

    always #2 clk = ~clk;

    wp_unit #(.NUM_BP(NUM_BP), .ADDR_W(ADDR_W), .MASK_W(MASK_W)) i_wp_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ctrl(wr_ctrl),
        .wr_idx(wr_idx), .wr_data(wr_data), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_load(acc_load), .acc_store(acc_store),
        .bp_hit(bp_hit), .bp_idx(bp_idx)
    );

    function automatic logic [MASK_W-1:0] cut_mask(input logic [MASK_W-1:0] f);
        logic [MASK_W-1:0] r;
        logic k;
        k = 1'b1;
        for (int i = MASK_W - 1; i >= 0; i--) begin
            k = k & f[i];
            r[i] = k;
        end
        return r;
    endfunction

    function automatic logic [IDX_W:0] expect_hit(input logic v, input logic [ADDR_W-1:0] a,
                                                  input logic ld, input logic st);
        for (int i = 0; i < NUM_BP; i++) begin
            logic [ADDR_W-1:0] fm;
            fm = {{(ADDR_W-MASK_W){1'b1}}, m_mask[i]};
            if (v && ((ld && m_ld[i]) || (st && m_st[i])) && ((a & fm) == (m_addr[i] & fm)))
                return {1'b1, IDX_W'(i)};
        end
        return '0;
    endfunction

    task automatic step(input logic we, input logic wc, input int wi, input logic [ADDR_W-1:0] wd,
                        input logic v, input logic [ADDR_W-1:0] a, input logic ld, input logic st,
                        input string tag);
        logic [IDX_W:0] exp;
        @(negedge clk);
        wr_en = we; wr_ctrl = wc; wr_idx = IDX_W'(wi); wr_data = wd;
        acc_valid = v; acc_addr = a; acc_load = ld; acc_store = st;
        #1;
        exp = expect_hit(v, a, ld, st);
        checks++;
        if ({bp_hit, bp_idx} !== exp) begin
            failures++;
            $display("FAIL %s: hit/idx actual=%b/%0d expected=%b/%0d", tag, bp_hit, bp_idx,
                     exp[IDX_W], exp[IDX_W-1:0]);
        end
        @(posedge clk);
        if (we) begin
            if (wc) begin
                m_mask[wi] = cut_mask(wd[MASK_W-1:0]);
                m_ld[wi]   = wd[MASK_W];
                m_st[wi]   = wd[MASK_W+1];
            end else begin
                m_addr[wi] = wd;
            end
        end
    endtask

    task automatic wr(input logic wc, input int wi, input logic [ADDR_W-1:0] wd, input string tag);
        step(1'b1, wc, wi, wd, 1'b0, '0, 1'b0, 1'b0, tag);
    endtask

    task automatic acc(input logic [ADDR_W-1:0] a, input logic ld, input logic st, input string tag);
        step(1'b0, 1'b0, 0, '0, 1'b1, a, ld, st, tag);
    endtask

    // control word: bit7 store enable, bit6 load enable, bits5:0 mask field
    function automatic logic [ADDR_W-1:0] cw(input logic st, input logic ld, input logic [5:0] f);
        return {{(ADDR_W-8){1'b0}}, st, ld, f};
    endfunction

    initial begin
        for (int i = 0; i < NUM_BP; i++) begin
            m_addr[i] = '0; m_mask[i] = '0; m_ld[i] = 1'b0; m_st[i] = 1'b0;
        end
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        acc(32'h0, 1'b1, 1'b1, "R1 reset state");
        acc(32'h0, 1'b1, 1'b0, "R1 reset state load");

        wr(1'b0, 0, 32'h1000, "R3 setup");
        wr(1'b1, 0, cw(1'b0, 1'b1, 6'b111100), "R3 setup");
        acc(32'h1002, 1'b1, 1'b0, "R3 load hit");
        acc(32'h1002, 1'b0, 1'b1, "R2 store ignored");
        acc(32'h1004, 1'b1, 1'b0, "R4 outside region");
        acc(32'h1003, 1'b1, 1'b0, "R4 region top");

        wr(1'b0, 1, 32'h2000, "R2 setup");
        wr(1'b1, 1, cw(1'b1, 1'b0, 6'b111111), "R2 setup");
        acc(32'h2000, 1'b0, 1'b1, "R2 store hit");
        acc(32'h2000, 1'b1, 1'b0, "R3 load ignored");
        acc(32'h2001, 1'b0, 1'b1, "R4 exact byte");

        wr(1'b0, 2, 32'h3000, "R5 setup");
        wr(1'b1, 2, cw(1'b1, 1'b1, 6'b101111), "R5 setup");
        acc(32'h301F, 1'b1, 1'b0, "R5 truncated mask");
        acc(32'h3020, 1'b0, 1'b1, "R5 beyond region");

        wr(1'b0, 3, 32'h4000, "R6 setup");
        wr(1'b1, 3, cw(1'b0, 1'b0, 6'b000000), "R6 setup");
        acc(32'h4000, 1'b1, 1'b1, "R6 disarmed");

        wr(1'b0, 3, 32'h1000, "R7 setup");
        wr(1'b1, 3, cw(1'b1, 1'b1, 6'b111111), "R7 setup");
        acc(32'h1000, 1'b1, 1'b0, "R7 lowest index");
        acc(32'h1000, 1'b0, 1'b1, "R7 only bp3 for store");

        step(1'b1, 1'b1, 0, cw(1'b0, 1'b0, 6'b111111), 1'b1, 32'h1000, 1'b1, 1'b0, "R8 same-cycle old");
        acc(32'h1000, 1'b1, 1'b0, "R8 next cycle new");

        step(1'b0, 1'b0, 0, '0, 1'b0, 32'h1000, 1'b1, 1'b1, "R9 idle no hit");
        step(1'b0, 1'b0, 0, '0, 1'b0, 32'h2000, 1'b0, 1'b1, "R10 idle idx zero");

        for (int n = 0; n < 400; n++) begin
            logic [ADDR_W-1:0] base;
            base = {18'h0, 2'($urandom_range(0, 3)), 12'h0} + 32'h1000;
            if ($urandom_range(0, 3) == 0) begin
                if ($urandom_range(0, 1) == 1)
                    step(1'b1, 1'b1, $urandom_range(0, 3), 32'($urandom), 1'b1,
                         base | 32'($urandom_range(0, 63)), 1'($urandom), 1'($urandom), "R4 random");
                else
                    step(1'b1, 1'b0, $urandom_range(0, 3), base | 32'($urandom_range(0, 63)), 1'b1,
                         base | 32'($urandom_range(0, 63)), 1'($urandom), 1'($urandom), "R8 random");
            end else begin
                step(1'b0, 1'b0, 0, '0, 1'($urandom_range(0, 7) != 0),
                     base | 32'($urandom_range(0, 63)), 1'($urandom), 1'($urandom), "R7 random");
            end
        end

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule